// File: doc/BRIEF.md
# Multicast Spike Packet Router

This block takes one 40-bit packet per clock from the on-chip input fabric and hands copies of it to 26 destinations: six inter-chip links (outputs 0 to 5) and twenty local processors (outputs 6 to 25, where output 6 is the monitor processor). The work is split across three registered stages. The first stage checks the packet for errors. The second stage computes a destination vector with one of three engines, chosen by the packet type. The third stage presents the packet on every selected output and holds it until each copy has been taken.

Multicast packets are matched against a small table that is searched by key under a per-entry mask. A multicast packet that matches no entry is sent on the link opposite the one it arrived on. Point-to-point packets index a direct table that names one output. Nearest-neighbour packets carry their link number in the packet itself. A link copy that stays blocked for too long is moved onto the two links on either side of it, and each such move is reported. A processor copy, or a detoured copy, that stays stuck for too long is dropped and reported. The tables are loaded through a one-word write port.

Top module: `spike_router`

## Requirements
- R1: A packet accepted on a rising edge (in_valid and in_ready both high) appears on out_valid/out_data after the third rising edge that follows, counting the accepting edge as the first. While every output is ready, one packet is accepted on every clock.
- R2: Stage one drops a packet whose 40 bits have odd parity (bit 0 is the even-parity bit), or whose type field in_pkt[39:38] is 2'b11. For each dropped packet, bad_pkt pulses high for one cycle, one edge after acceptance, and no output sees the packet.
- R3: Type 2'b00 is multicast. Let key be pkt[31:8]. Entry e matches when ((key ^ entry key) & entry mask) == 0 and its 26-bit output vector is non-zero. An entry whose vector is zero is disabled. The lowest-indexed matching entry supplies the destination vector.
- R4: A multicast packet that matches no entry goes to a default route. If in_src is a link k (k < 6), it goes to link (k+3) mod 6. Otherwise it goes to output 6.
- R5: Type 2'b01 is point-to-point. pkt[13:8] indexes a 64-entry table of 5-bit output numbers. A value of 26 or more discards the packet silently.
- R6: Type 2'b10 is nearest-neighbour. If pkt[10:8] is below 6, the packet goes to that link. Otherwise it goes to output 6.
- R7: Stage three raises out_valid for every selected output. Each copy leaves on the edge where its out_ready is high. The next packet enters stage three only once every copy has gone.
- R8: While stage three still holds a copy that cannot leave on this edge, in_ready is low and the whole pipeline holds. During this time out_data stays stable.
- R9: Suppose a link k holds a copy, and that copy is not a detour. If out_ready[k] stays low for 64 consecutive cycles, then on the 64th edge the copy is removed from k and placed on links (k+1) mod 6 and (k+5) mod 6. On the same edge, emerg_valid pulses with bit k set in emerg_links.
- R10: A copy for a processor output, or a detoured copy on a link, that sees 64 consecutive not-ready cycles is dropped, and copy_timeout pulses for one cycle.
- R11: When tbl_we is high, tbl_sel chooses what is written at tbl_addr, and the write takes effect on the next edge. The choices are 0 for the entry key (wdata[23:0]), 1 for the entry mask (wdata[23:0]), 2 for the entry vector (wdata[25:0]), and 3 for the point-to-point output number (wdata[4:0]). Multicast writes use tbl_addr[3:0].
- R12: After reset, in_ready is 1 and out_valid is 0. All multicast entries are disabled, and all point-to-point entries hold 31 (discard).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Router can take a packet this cycle |
| in_pkt | input | 40 | Input packet |
| in_src | input | 5 | Port the packet arrived on (0-5 links, others local) |
| out_valid | output | 26 | Per-output copy valid |
| out_ready | input | 26 | Per-output ready |
| out_data | output | 40 | Packet shared by all outputs |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table field select |
| tbl_addr | input | 6 | Table entry address |
| tbl_wdata | input | 26 | Table write data |
| bad_pkt | output | 1 | Pulse: packet dropped for parity or type |
| emerg_valid | output | 1 | Pulse: emergency detour taken |
| emerg_links | output | 6 | Links whose copies were detoured |
| copy_timeout | output | 1 | Pulse: a copy was dropped after time-out |

## Verification
The hardest state to reach is a detoured copy that fails as well. To get there, the link and both of its neighbours must be held not-ready through two full 64-cycle windows, in order, while everything before them stays idle. The bench drives this case directly on link 0, which also covers the wrap-around of the adjacency. It checks the cycle before each window expires, and the cycle of expiry. A random phase follows, with mixed packet types, bad packets and sparse readiness. That phase checks the back-pressure paths against a behavioural reference on every clock.

// File: rtl/spike_router.sv
module spike_router #(
  parameter int NLINK = 6,
  parameter int NCPU  = 20,
  parameter int MC_N  = 16,
  parameter int P2P_N = 64,
  parameter int TMO   = 64,
  localparam int NOUT   = NLINK + NCPU,
  localparam int OUT_W  = $clog2(NOUT),
  localparam int P2P_AW = $clog2(P2P_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [39:0]       in_pkt,
  input  logic [OUT_W-1:0]  in_src,
  output logic [NOUT-1:0]   out_valid,
  input  logic [NOUT-1:0]   out_ready,
  output logic [39:0]       out_data,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [P2P_AW-1:0] tbl_addr,
  input  logic [NOUT-1:0]   tbl_wdata,
  output logic              bad_pkt,
  output logic              emerg_valid,
  output logic [NLINK-1:0]  emerg_links,
  output logic              copy_timeout
);
  localparam int KEY_W = 24;
  localparam int MC_AW = $clog2(MC_N);
  localparam int LK_W  = $clog2(NLINK);
  localparam int CNT_W = $clog2(TMO);
  localparam logic [OUT_W:0] NL_C   = (OUT_W+1)'(NLINK);
  localparam logic [OUT_W:0] HALF_C = (OUT_W+1)'(NLINK / 2);
  localparam logic [OUT_W:0] NOUT_C = (OUT_W+1)'(NOUT);
  localparam logic [LK_W:0]  NL_L   = (LK_W+1)'(NLINK);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TMO - 1);

  logic [KEY_W-1:0] mc_key  [MC_N];
  logic [KEY_W-1:0] mc_mask [MC_N];
  logic [NOUT-1:0]  mc_vec  [MC_N];
  logic [OUT_W-1:0] p2p_port[P2P_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MC_N; e++) begin
        mc_key[e]  <= '0;
        mc_mask[e] <= '0;
        mc_vec[e]  <= '0;
      end
      for (int p = 0; p < P2P_N; p++) p2p_port[p] <= '1;
    end else if (tbl_we) begin
      case (tbl_sel)
        2'd0: mc_key[tbl_addr[MC_AW-1:0]]  <= tbl_wdata[KEY_W-1:0];
        2'd1: mc_mask[tbl_addr[MC_AW-1:0]] <= tbl_wdata[KEY_W-1:0];
        2'd2: mc_vec[tbl_addr[MC_AW-1:0]]  <= tbl_wdata;
        default: p2p_port[tbl_addr] <= tbl_wdata[OUT_W-1:0];
      endcase
    end
  end

  logic             s1v, s2v, s3v, adv;
  logic [39:0]      s1_pkt, s2_pkt, s3_pkt;
  logic [OUT_W-1:0] s1_src;
  logic [NOUT-1:0]  s2_vec, pend, route_vec;
  logic [NLINK-1:0] emg;

  wire s1_ok = ~^s1_pkt && (s1_pkt[39:38] != 2'b11);
  wire [KEY_W-1:0] s1_key = s1_pkt[31:8];

  logic [MC_N-1:0] mc_hit;
  for (genvar e = 0; e < MC_N; e++) begin : g_hit
    assign mc_hit[e] = (|mc_vec[e]) && (((s1_key ^ mc_key[e]) & mc_mask[e]) == '0);
  end

  logic [NOUT-1:0] mc_sel;
  logic            mc_any;
  always_comb begin
    mc_sel = '0;
    mc_any = 1'b0;
    for (int e = MC_N - 1; e >= 0; e--)
      if (mc_hit[e]) begin
        mc_sel = mc_vec[e];
        mc_any = 1'b1;
      end
  end

  logic [OUT_W:0] opp;
  always_comb begin
    opp = {1'b0, s1_src} + HALF_C;
    if ({1'b0, s1_src} >= NL_C) opp = NL_C;
    else if (opp >= NL_C)       opp = opp - NL_C;
  end

  wire [OUT_W-1:0] p2p_sel = p2p_port[s1_pkt[8 +: P2P_AW]];
  wire [LK_W-1:0]  nn_link = s1_pkt[8 +: LK_W];

  always_comb begin
    case (s1_pkt[39:38])
      2'b00:   route_vec = mc_any ? mc_sel : NOUT'(1) << opp;
      2'b01:   route_vec = ({1'b0, p2p_sel} < NOUT_C) ? NOUT'(1) << p2p_sel : '0;
      default: route_vec = ({1'b0, nn_link} < NL_L) ? NOUT'(1) << nn_link : NOUT'(1) << NLINK;
    endcase
  end

  logic [NOUT-1:0]  exp_v, base_v, pend_nx;
  logic [NLINK-1:0] lnk_exp, det;
  logic [CNT_W-1:0] wait_cnt [NOUT];

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign exp_v[i]  = pend[i] && !out_ready[i] && (wait_cnt[i] == CNT_MAX);
    assign base_v[i] = pend[i] && !out_ready[i] && !exp_v[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         wait_cnt[i] <= '0;
      else if (base_v[i]) wait_cnt[i] <= wait_cnt[i] + 1'b1;
      else                wait_cnt[i] <= '0;
  end

  for (genvar k = 0; k < NLINK; k++) begin : g_det
    localparam int UP = (k + 1) % NLINK;
    localparam int DN = (k + NLINK - 1) % NLINK;
    assign lnk_exp[k] = exp_v[k] && !emg[k];
    assign det[k]     = lnk_exp[UP] || lnk_exp[DN];
  end

  assign pend_nx   = base_v | {{NCPU{1'b0}}, det};
  assign adv       = !s3v || (pend_nx == '0);
  assign in_ready  = adv;
  assign out_valid = pend;
  assign out_data  = s3_pkt;
  wire tmo_any = |(exp_v & ~{{NCPU{1'b0}}, lnk_exp});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1v <= 1'b0; s2v <= 1'b0; s3v <= 1'b0;
      s1_pkt <= '0; s2_pkt <= '0; s3_pkt <= '0; s1_src <= '0;
      s2_vec <= '0; pend <= '0; emg <= '0;
      bad_pkt <= 1'b0; emerg_valid <= 1'b0; emerg_links <= '0; copy_timeout <= 1'b0;
    end else begin
      bad_pkt      <= adv && s1v && !s1_ok;
      emerg_valid  <= |lnk_exp;
      emerg_links  <= lnk_exp;
      copy_timeout <= tmo_any;
      if (adv) begin
        s1v    <= in_valid;
        s1_pkt <= in_pkt;
        s1_src <= in_src;
        s2v    <= s1v && s1_ok;
        s2_pkt <= s1_pkt;
        s2_vec <= route_vec;
        s3v    <= s2v && (s2_vec != '0);
        s3_pkt <= s2_pkt;
        pend   <= s2v ? s2_vec : '0;
        emg    <= '0;
      end else begin
        pend <= pend_nx;
        emg  <= (emg & base_v[NLINK-1:0]) | det;
      end
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (s3v && !in_ready) |=> $stable(out_data)); // R8
  AST_STALL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid != '0)); // R8
  AST_EMERG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_valid |-> ((emerg_links & ~$past(out_valid[NLINK-1:0])) == '0)); // R9
  AST_EMERG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_valid |-> ((emerg_links & $past(out_ready[NLINK-1:0])) == '0)); // R9
  AST_TMO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    copy_timeout |-> ($past(out_valid & ~out_ready) != '0)); // R10
  AST_BAD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pkt |-> $past(in_ready)); // R2
endmodule

// File: tb/spike_router_bench.sv
module spike_router_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, tbl_we, bad_pkt, emerg_valid, copy_timeout;
  logic [39:0] in_pkt, out_data;
  logic [4:0]  in_src;
  logic [25:0] out_valid, out_ready, tbl_wdata;
  logic [1:0]  tbl_sel;
  logic [5:0]  tbl_addr, emerg_links;

  spike_router u_spike_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .in_src(in_src), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .bad_pkt(bad_pkt), .emerg_valid(emerg_valid), .emerg_links(emerg_links),
    .copy_timeout(copy_timeout));

  int checks = 0, fails = 0;
  string cur_req = "R12";

  logic [23:0] mkey [16];
  logic [23:0] mmask[16];
  logic [25:0] mvec [16];
  int          p2p  [64];
  bit          m1v, m2v, m3v, mbad, memv, mtmo;
  logic [39:0] m1pkt, m2pkt, m3pkt;
  int          m1src;
  logic [25:0] m2vec, mpend;
  logic [5:0]  memg, mlinks;
  int          mcnt[26];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pok(logic [39:0] p);
    return ((^p) == 1'b0) && (p[39:38] != 2'b11);
  endfunction

  function automatic logic [25:0] route(logic [39:0] p, int src);
    logic [23:0] key;
    key = p[31:8];
    if (p[39:38] == 2'b00) begin
      for (int e = 0; e < 16; e++)
        if (mvec[e] != 0 && ((key ^ mkey[e]) & mmask[e]) == 0) return mvec[e];
      if (src < 6) return 26'd1 << ((src + 3) % 6);
      return 26'd1 << 6;
    end
    if (p[39:38] == 2'b01) begin
      if (p2p[p[13:8]] < 26) return 26'd1 << p2p[p[13:8]];
      return '0;
    end
    if (p[10:8] < 6) return 26'd1 << p[10:8];
    return 26'd1 << 6;
  endfunction

  function automatic logic [39:0] mk(logic [1:0] t, logic [23:0] key, bit flip);
    logic [39:0] p;
    p = {t, 6'd0, key, 8'd0};
    p[0] = (^p[39:1]) ^ flip;
    return p;
  endfunction

  task automatic step();
    logic [25:0] ex, bs, dt, pn;
    logic [5:0]  le;
    bit          tm, adv, nbad;
    @(negedge clk);
    #1;
    le = '0; dt = '0; tm = 0;
    for (int i = 0; i < 26; i++) begin
      ex[i] = mpend[i] && !out_ready[i] && mcnt[i] == 63;
      bs[i] = mpend[i] && !out_ready[i] && !ex[i];
    end
    for (int k = 0; k < 6; k++)
      if (ex[k] && !memg[k]) begin
        le[k] = 1'b1;
        dt[(k + 1) % 6] = 1'b1;
        dt[(k + 5) % 6] = 1'b1;
      end
    for (int i = 0; i < 26; i++) if (ex[i] && !(i < 6 && le[i])) tm = 1;
    pn  = bs | dt;
    adv = !m3v || pn == 0;
    chk(cur_req, "in_ready", in_ready, adv);
    chk(cur_req, "out_valid", out_valid, m3v ? mpend : 26'd0);
    if (m3v) chk(cur_req, "out_data", out_data, m3pkt);
    chk(cur_req, "bad_pkt", bad_pkt, mbad);
    chk(cur_req, "emerg_valid", emerg_valid, memv);
    chk(cur_req, "emerg_links", emerg_links, mlinks);
    chk(cur_req, "copy_timeout", copy_timeout, mtmo);
    for (int i = 0; i < 26; i++) mcnt[i] = bs[i] ? mcnt[i] + 1 : 0;
    nbad = adv && m1v && !pok(m1pkt);
    memv = |le; mlinks = le; mtmo = tm; mbad = nbad;
    if (adv) begin
      m3v = m2v && m2vec != 0; m3pkt = m2pkt; mpend = m2v ? m2vec : '0; memg = '0;
      m2v = m1v && pok(m1pkt); m2pkt = m1pkt; m2vec = route(m1pkt, m1src);
      m1v = in_valid; m1pkt = in_pkt; m1src = int'(in_src);
    end else begin
      mpend = pn;
      memg  = (memg & bs[5:0]) | dt[5:0];
    end
    if (tbl_we)
      case (tbl_sel)
        2'd0: mkey[tbl_addr[3:0]]  = tbl_wdata[23:0];
        2'd1: mmask[tbl_addr[3:0]] = tbl_wdata[23:0];
        2'd2: mvec[tbl_addr[3:0]]  = tbl_wdata;
        default: p2p[tbl_addr] = int'(tbl_wdata[4:0]);
      endcase
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] s, logic [5:0] a, logic [25:0] d);
    tbl_we = 1; tbl_sel = s; tbl_addr = a; tbl_wdata = d;
    step();
    tbl_we = 0;
  endtask

  task automatic send(logic [39:0] p, int src);
    in_valid = 1; in_pkt = p; in_src = 5'(src);
    step();
    in_valid = 0;
  endtask

  task automatic look(string req, logic [39:0] p, int src, logic [25:0] exp);
    cur_req = req;
    send(p, src);
    step(); step();
    chk(req, "route", out_valid, exp);
    step();
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; in_valid = 0; in_pkt = '0; in_src = '0; out_ready = '1;
    tbl_we = 0; tbl_sel = '0; tbl_addr = '0; tbl_wdata = '0;
    for (int e = 0; e < 16; e++) begin mkey[e] = 0; mmask[e] = 0; mvec[e] = 0; end
    for (int p = 0; p < 64; p++) p2p[p] = 31;
    for (int i = 0; i < 26; i++) mcnt[i] = 0;
    m1v = 0; m2v = 0; m3v = 0; mbad = 0; memv = 0; mtmo = 0; mlinks = 0; memg = 0;
    mpend = 0; m1pkt = 0; m2pkt = 0; m3pkt = 0; m2vec = 0; m1src = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R12", "in_ready", in_ready, 1);
    chk("R12", "out_valid", out_valid, 0);
    step();
    look("R12", mk(2'b01, 24'h000009, 0), 0, 26'd0);
    look("R12", mk(2'b00, 24'h00AB12, 0), 0, 26'd1 << 3);

    cur_req = "R11";
    wr(0, 0, 26'h00AB00); wr(1, 0, 26'hFFFF00); wr(2, 0, (26'd1 << 3) | (26'd1 << 10));
    wr(0, 1, 26'h00AB12); wr(1, 1, 26'hFFFFFF); wr(2, 1, 26'd1 << 20);
    wr(0, 2, 26'h100000); wr(1, 2, 26'hF00000);
    wr(2, 2, 26'h0000047 | (26'd1 << 25));
    wr(3, 5, 26'd17); wr(3, 7, 26'd30);

    look("R3", mk(2'b00, 24'h00AB12, 0), 0, (26'd1 << 3) | (26'd1 << 10));
    look("R3", mk(2'b00, 24'h00AB77, 0), 0, (26'd1 << 3) | (26'd1 << 10));
    look("R3", mk(2'b00, 24'h1ABCDE, 0), 0, 26'h0000047 | (26'd1 << 25));
    look("R4", mk(2'b00, 24'h000001, 0), 1, 26'd1 << 4);
    look("R4", mk(2'b00, 24'h000001, 0), 5, 26'd1 << 2);
    look("R4", mk(2'b00, 24'h000001, 0), 9, 26'd1 << 6);
    look("R5", mk(2'b01, 24'h000005, 0), 0, 26'd1 << 17);
    look("R5", mk(2'b01, 24'h000007, 0), 0, 26'd0);
    look("R6", mk(2'b10, 24'h000002, 0), 0, 26'd1 << 2);
    look("R6", mk(2'b10, 24'h000007, 0), 0, 26'd1 << 6);
    cur_req = "R11";
    wr(3, 5, 26'd2);
    look("R11", mk(2'b01, 24'h000005, 0), 0, 26'd1 << 2);

    cur_req = "R2";
    send(mk(2'b00, 24'h00AB12, 1), 0);
    step(); chk("R2", "bad_pkt", bad_pkt, 1);
    step(); chk("R2", "out_valid", out_valid, 0);
    send(mk(2'b11, 24'h000001, 0), 0);
    step(); chk("R2", "bad_pkt", bad_pkt, 1);
    step(); chk("R2", "out_valid", out_valid, 0);
    step();

    cur_req = "R1";
    send(mk(2'b10, 24'h000001, 0), 0);
    send(mk(2'b10, 24'h000002, 0), 0);
    send(mk(2'b10, 24'h000004, 0), 0);
    chk("R1", "first", out_valid, 26'd1 << 1);
    step(); chk("R1", "second", out_valid, 26'd1 << 2);
    step(); chk("R1", "third", out_valid, 26'd1 << 4);
    step(); step();

    cur_req = "R7";
    send(mk(2'b00, 24'h100000, 0), 0);
    out_ready = (26'd1 << 0) | (26'd1 << 6);
    step(); step();
    chk("R7", "all copies", out_valid, 26'h0000047 | (26'd1 << 25));
    chk("R8", "in_ready stall", in_ready, 0);
    step(); chk("R7", "left copies", out_valid, 26'h0000006 | (26'd1 << 25));
    step(); step();
    chk("R8", "data held", out_data, mk(2'b00, 24'h100000, 0));
    out_ready = '1;
    step(); chk("R7", "drained", out_valid, 0);

    cur_req = "R9";
    out_ready = ~(26'd1 << 3);
    send(mk(2'b10, 24'h000003, 0), 0);
    step(); step();
    repeat (63) step();
    chk("R9", "still held", out_valid, 26'd1 << 3);
    step();
    chk("R9", "detour", out_valid, (26'd1 << 2) | (26'd1 << 4));
    chk("R9", "emerg_links", {emerg_valid, emerg_links}, {1'b1, 6'b001000});
    out_ready = '1;
    step(); step();

    cur_req = "R10";
    out_ready = ~26'h0000023;
    send(mk(2'b10, 24'h000000, 0), 0);
    step(); step();
    repeat (64) step();
    chk("R10", "wrap detour", out_valid, 26'h0000022);
    repeat (63) step();
    chk("R10", "detour held", out_valid, 26'h0000022);
    step();
    chk("R10", "detour dropped", {copy_timeout, out_valid}, {1'b1, 26'd0});
    out_ready = ~(26'd1 << 17);
    wr(3, 5, 26'd17);
    send(mk(2'b01, 24'h000005, 0), 0);
    step(); step();
    repeat (64) step();
    chk("R10", "cpu dropped", {copy_timeout, emerg_valid, out_valid}, {2'b10, 26'd0});
    out_ready = '1;
    step();

    cur_req = "R8";
    lf = 32'h1F2E3D4C;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      out_ready = 26'(lf) | 26'(lf >> 5) | (n % 150 < 100 ? 26'(lf >> 9) : 26'd0);
      in_valid = lf[3] | lf[7];
      in_src = 5'(lf[14:10] % 26);
      in_pkt = mk(lf[17:16], {lf[12] ? 8'h00 : 8'h1A, lf[27:20], lf[31:24]}, lf[30] & lf[29] & lf[28]);
      step();
    end
    in_valid = 0; out_ready = '1;
    repeat (5) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule